// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters: seconds, minutes, hours (24-hour), a free-running weekday, day of month, month and a two-digit year. A sub-second tick arrives on `tick_i` at `TICK_DIV` pulses per second. An internal phase counter turns every `TICK_DIV` accepted ticks into one step of the seconds counter, and carries then ripple through the chain in the same clock cycle. The length of each month, including a 29-day February in leap years, comes from the current month and year bytes. A year counts as leap when its two digits divide by four, so 00 is a leap year.

A register file sets the time by presenting all seven bytes and pulsing `load_i`. The load replaces every field in one cycle and restarts the sub-second phase. Bit 7 of the seconds byte is a run/stop flag. It is set out of reset, and while it is set neither the phase nor any field moves. Every output is a register, and bits that lie above a field's width always read as zero.

Top module: `bcd_calendar_chain`

## Requirements
- R1: After reset the outputs read seconds 0x80 (stop flag set, 00 s), minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00.
- R2: Every field stays within its packed-BCD range: seconds and minutes 00–59, hours 00–23, weekday 1–7, date 01 to the current month's length, month 01–12, year 00–99. Loads must present in-range values.
- R3: While running, the seconds advance by one after every `TICK_DIV` accepted ticks. Seconds 59 wraps to 00 and steps the minutes, minutes 59 wraps to 00 and steps the hours, and hours 23 wraps to 00 (midnight), all on the same clock edge.
- R4: At midnight the date steps by one. After the last day of the month it returns to 01 and the month steps. April, June, September and November have 30 days, and the other months except February have 31.
- R5: February has 29 days when the year byte's value divides by 4 (00 included) and 28 days otherwise.
- R6: At midnight on December 31 the month and date become 01, and the year steps. Year 99 wraps to 00.
- R7: The weekday steps at every midnight and wraps from 7 to 1, regardless of date and month.
- R8: While the stop flag (seconds bit 7) is 1, ticks are ignored: no field and no sub-second phase changes. After a load clears the flag, counting resumes.
- R9: A `load_i` pulse writes all seven fields and the stop flag on the next edge and clears the sub-second phase. It takes priority over a tick in the same cycle, and the next second change comes after a full `TICK_DIV` further ticks.
- R10: Loaded bytes are masked to their field widths: seconds and minutes 7 bits, hours and date 6 bits, weekday 3 bits, month 5 bits, year 8 bits. Seconds bit 7 is the stop flag. All other high bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sub-second tick, one cycle per pulse |
| load_i | input | 1 | Load all fields from the ld_* inputs |
| ld_sec_i | input | 8 | Seconds to load; bit 7 is the stop flag |
| ld_min_i | input | 8 | Minutes to load |
| ld_hour_i | input | 8 | Hours to load |
| ld_wday_i | input | 8 | Weekday to load |
| ld_date_i | input | 8 | Day of month to load |
| ld_month_i | input | 8 | Month to load |
| ld_year_i | input | 8 | Two-digit year to load |
| sec_o | output | 8 | Stop flag in bit 7, BCD seconds below |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| wday_o | output | 8 | Weekday 1–7 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The embedded assertions check on every cycle that each field stays within its range limit, including the date against the length of the current month. They also check that a wrapping field lands on its low value, that a stopped chain and its phase hold still, and that a load clears the phase. Only the bench scenarios can show the actual calendar arithmetic: which months have 30 days, the February leap rule across years 00, 23 and 24, the year-99 wrap, weekday order and the exact tick count between seconds. The bench compares every output byte with a behavioural model after random loads near rollover points and random tick and stop patterns.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef logic [7:0] bcd8_t;

  localparam int NF     = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_WDAY = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Two-digit year divisible by four, evaluated directly on BCD digits
  function automatic logic year_is_leap(input bcd8_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd8_t month_len(input bcd8_t mo, input bcd8_t y);
    case (mo)
      8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd8_t field_mask(input int f);
    case (f)
      F_SEC, F_MIN:   return 8'h7F;
      F_HOUR, F_DATE: return 8'h3F;
      F_WDAY:         return 8'h07;
      F_MON:          return 8'h1F;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic bcd8_t field_low(input int f);
    return (f == F_WDAY || f == F_DATE || f == F_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/cal_phase.sv
module cal_phase #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic load_i,
  input  logic stop_i,
  output logic sec_step_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;
  logic          accept;

  assign accept     = tick_i && !stop_i && !load_i;
  assign sec_step_o = accept && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || load_i)  cnt <= '0;
    else if (accept)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt == '0)); // R9
  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !load_i) |=> $stable(cnt)); // R8
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter bcd8_t RST_VAL = 8'h00,
  parameter bcd8_t LO_VAL  = 8'h00,
  parameter bcd8_t MASK    = 8'hFF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load_i,
  input  bcd8_t load_val_i,
  input  logic  step_i,
  input  bcd8_t hi_i,
  output bcd8_t val_o,
  output logic  carry_o
);
  assign carry_o = step_i && (val_o == hi_i);

  always_ff @(posedge clk) begin
    if (rst)          val_o <= RST_VAL;
    else if (load_i)  val_o <= load_val_i & MASK;
    else if (step_i)  val_o <= (val_o == hi_i) ? LO_VAL : bcd_inc(val_o);
  end

  AST_FIELD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (val_o >= LO_VAL) && (val_o <= hi_i)); // R2
  AST_WRAP_TO_LOW: assert property (@(posedge clk) disable iff (rst)
    (carry_o && !load_i) |=> (val_o == LO_VAL)); // R3
endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain
  import cal_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_wday_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_month_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic  stop_q;
  logic  sec_step;
  bcd8_t val   [NF];
  bcd8_t ldv   [NF];
  bcd8_t hi    [NF];
  logic  step  [NF];
  logic  carry [NF];

  always_ff @(posedge clk) begin
    if (rst)         stop_q <= 1'b1;
    else if (load_i) stop_q <= ld_sec_i[7];
  end

  cal_phase #(.TICK_DIV(TICK_DIV)) u_phase (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
    .stop_i(stop_q), .sec_step_o(sec_step)
  );

  always_comb begin
    ldv[F_SEC]  = ld_sec_i;   ldv[F_MIN]  = ld_min_i;
    ldv[F_HOUR] = ld_hour_i;  ldv[F_WDAY] = ld_wday_i;
    ldv[F_DATE] = ld_date_i;  ldv[F_MON]  = ld_month_i;
    ldv[F_YEAR] = ld_year_i;

    hi[F_SEC]  = 8'h59;  hi[F_MIN]  = 8'h59;
    hi[F_HOUR] = 8'h23;  hi[F_WDAY] = 8'h07;
    hi[F_DATE] = month_len(val[F_MON], val[F_YEAR]);
    hi[F_MON]  = 8'h12;  hi[F_YEAR] = 8'h99;

    // Carry routing: midnight feeds both weekday and date
    step[F_SEC]  = sec_step;
    step[F_MIN]  = carry[F_SEC];
    step[F_HOUR] = carry[F_MIN];
    step[F_WDAY] = carry[F_HOUR];
    step[F_DATE] = carry[F_HOUR];
    step[F_MON]  = carry[F_DATE];
    step[F_YEAR] = carry[F_MON];
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    cal_bcd_field #(
      .RST_VAL(field_low(i)), .LO_VAL(field_low(i)), .MASK(field_mask(i))
    ) u_field (
      .clk(clk), .rst(rst), .load_i(load_i), .load_val_i(ldv[i]),
      .step_i(step[i]), .hi_i(hi[i]), .val_o(val[i]), .carry_o(carry[i])
    );
  end

  assign sec_o   = val[F_SEC] | {stop_q, 7'b0};
  assign min_o   = val[F_MIN];
  assign hour_o  = val[F_HOUR];
  assign wday_o  = val[F_WDAY];
  assign date_o  = val[F_DATE];
  assign month_o = val[F_MON];
  assign year_o  = val[F_YEAR];

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !load_i) |=> $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o})); // R8
  AST_WDAY_FOLLOWS_MIDNIGHT: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !carry[F_HOUR]) |=> $stable(wday_o)); // R7
endmodule

// File: tb/sim_bcd_calendar_chain.sv
`timescale 1ns/1ps
module sim_bcd_calendar_chain;
  localparam int TD = 4;

  logic clk = 0, rst = 1, tick = 0, load = 0;
  logic [7:0] ls, lm, lh, lw, ld, lmo, ly;
  logic [7:0] so, mo_o, ho, wo, do_o, mno, yo;
  int checks = 0, failures = 0;

  // reference state
  int s, m, h, wd, d, mo, y, stp, ph;

  always #2 clk = ~clk;

  bcd_calendar_chain #(.TICK_DIV(TD)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .load_i(load),
    .ld_sec_i(ls), .ld_min_i(lm), .ld_hour_i(lh), .ld_wday_i(lw),
    .ld_date_i(ld), .ld_month_i(lmo), .ld_year_i(ly),
    .sec_o(so), .min_o(mo_o), .hour_o(ho), .wday_o(wo),
    .date_o(do_o), .month_o(mno), .year_o(yo)
  );

  function automatic int b2i(input logic [7:0] b);
    return b[7:4] * 10 + b[3:0];
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int dim(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic advance();
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0;
          wd = (wd == 7) ? 1 : wd + 1;
          if (d == dim(mo, y)) begin
            d = 1;
            if (mo == 12) begin mo = 1; y = (y + 1) % 100; end
            else mo++;
          end else d++;
        end
      end
    end
  endtask

  task automatic check(input string tag);
    logic [7:0] es;
    es = i2b(s) | (stp ? 8'h80 : 8'h00);
    checks++;
    if (so !== es || mo_o !== i2b(m) || ho !== i2b(h) || wo !== 8'(wd) ||
        do_o !== i2b(d) || mno !== i2b(mo) || yo !== i2b(y)) begin
      failures++;
      $display("FAIL %s actual=%h:%h:%h wd%h %h/%h/%h expected=%h:%h:%h wd%h %h/%h/%h",
               tag, ho, mo_o, so, wo, do_o, mno, yo,
               i2b(h), i2b(m), es, 8'(wd), i2b(d), i2b(mo), i2b(y));
    end
  endtask

  // one clock: drive at negedge, model at posedge, release and sample at next negedge
  task automatic cyc(input logic t, input logic l, input string tag);
    tick = t; load = l;
    @(posedge clk);
    if (l) begin
      s = b2i(ls & 8'h7F); stp = ls[7]; m = b2i(lm & 8'h7F);
      h = b2i(lh & 8'h3F); wd = int'(lw & 8'h07); d = b2i(ld & 8'h3F);
      mo = b2i(lmo & 8'h1F); y = b2i(ly); ph = 0;
    end else if (t && !stp) begin
      ph++;
      if (ph == TD) begin ph = 0; advance(); end
    end
    @(negedge clk);
    tick = 0; load = 0;
    check(tag);
  endtask

  task automatic set_time(input int hh, input int mi, input int ss, input int w,
                          input int dd, input int mm, input int yy, input logic st,
                          input string tag);
    ls = i2b(ss) | (st ? 8'h80 : 8'h00); lm = i2b(mi); lh = i2b(hh);
    lw = 8'(w); ld = i2b(dd); lmo = i2b(mm); ly = i2b(yy);
    cyc(0, 1, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, tag);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1977));
    ls = 0; lm = 0; lh = 0; lw = 0; ld = 0; lmo = 0; ly = 0;
    s = 0; m = 0; h = 0; wd = 1; d = 1; mo = 1; y = 0; stp = 1; ph = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset");
    ticks(2 * TD, "R8 stopped after reset");

    // R9: load mid-phase restarts the second, load beats tick
    set_time(10, 20, 30, 3, 15, 6, 24, 0, "R9 load");
    ticks(TD - 1, "R9 partial");
    ls = 8'h00; lm = 8'h45; lh = 8'h12; lw = 8'h05; ld = 8'h10; lmo = 8'h03; ly = 8'h11;
    cyc(1, 1, "R9 load over tick");
    ticks(TD, "R9 full second after load");

    // R3: chain to midnight
    set_time(23, 59, 59, 4, 10, 5, 30, 0, "R3 setup");
    ticks(TD, "R3 midnight");
    // R4: 30-day and 31-day months
    set_time(23, 59, 59, 2, 30, 4, 30, 0, "R4 setup");
    ticks(TD, "R4 april end");
    set_time(23, 59, 59, 2, 30, 7, 30, 0, "R4 setup");
    ticks(TD, "R4 july 30");
    // R5: February across years
    set_time(23, 59, 59, 1, 28, 2, 24, 0, "R5 setup");
    ticks(TD, "R5 leap 24");
    set_time(23, 59, 59, 1, 28, 2, 23, 0, "R5 setup");
    ticks(TD, "R5 common 23");
    set_time(23, 59, 59, 1, 28, 2, 0, 0, "R5 setup");
    ticks(TD, "R5 leap 00");
    // R6 and R7: year wrap with weekday 7
    set_time(23, 59, 59, 7, 31, 12, 99, 0, "R6 setup");
    ticks(TD, "R6 R7 year wrap");
    // R8: stop then resume
    set_time(8, 0, 5, 2, 1, 1, 1, 1, "R8 stop load");
    ticks(3 * TD, "R8 stopped");
    ls = 8'h05;
    cyc(0, 1, "R8 release");
    ticks(2 * TD, "R8 resumed");
    // R10: garbage high bits masked
    ls = 8'h47; lm = 8'hC5; lh = 8'hD3; lw = 8'hF6; ld = 8'hC9; lmo = 8'hE8; ly = 8'h42;
    cyc(0, 1, "R10 masked load");
    ticks(TD, "R10 after masked load");

    // random: loads near rollover points with random ticks and stops
    for (int it = 0; it < 400; it++) begin
      int mm, yy, dd, r;
      mm = 1 + $urandom % 12;
      yy = $urandom % 100;
      r  = $urandom % 4;
      dd = (r == 0) ? dim(mm, yy) - 1 : (r == 3) ? 1 + $urandom % dim(mm, yy) : dim(mm, yy);
      set_time(23, 59, 58 + $urandom % 2, 1 + $urandom % 7, dd, mm, yy,
               ($urandom % 8) == 0, "R2 random load");
      for (int k = 0; k < 3 * TD; k++)
        cyc(($urandom % 4) != 0, 0, "R3 R4 R5 R6 R7 random run");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule